// File: doc/BRIEF.md
# Serial Character-Driven JTAG Pin Controller

This block turns a stream of single-byte ASCII commands into levels on the three JTAG driver pins (clock, mode select and data in) of a downstream test access port. Each byte arrives on a valid/ready input stream. The block decodes the byte, acts on it, and may return a one-byte answer on a valid/ready output stream. A host can therefore clock a TAP one half-period at a time over any byte link, such as a UART bridge or a socket-to-stream adapter.

The pin command is a digit. Its low three bits give the new clock, mode and data levels. A read command samples the TDO line and answers with an ASCII digit. A separate character starts a timed reset pulse towards the TAP, which returns it to Test-Logic-Reset. Two indicator characters are accepted and have no effect. A quit character closes the session, and the block then takes no more bytes until a session-start strobe arrives. Any other byte raises a one-cycle error strobe and is otherwise dropped.

Top module: `jtag_bitbang_decoder`

## Requirements
- R1: After reset, tck, tms, tdi, tap_reset, cmd_error, out_valid and session_closed are all 0, and in_ready is 1.
- R2: An accepted byte in the range 0x30..0x37 ('0'..'7') sets tck to bit 2, tms to bit 1 and tdi to bit 0 of that byte. The pins change one clock after the byte is accepted, and they change at no other time.
- R3: An accepted 0x52 ('R') raises out_valid one clock later. out_data is then 0x31 ('1') if tdo was high in the accepting cycle, and 0x30 ('0') if tdo was low.
- R4: While out_valid is high and out_ready is low, out_valid and out_data hold steady. out_valid falls one clock after a cycle in which out_valid and out_ready are both high.
- R5: An accepted 0x72 ('r') drives tap_reset high for exactly RST_CYCLES clocks, starting one clock after acceptance. Another 'r' restarts the count. The pins are left unchanged.
- R6: Accepted bytes 0x42 ('B') and 0x62 ('b') change no pin, produce no reply and raise no error.
- R7: An accepted 0x51 ('Q') sets session_closed one clock later. While session_closed is high, in_ready is 0 and no byte is taken.
- R8: A session_start pulse clears session_closed one clock later. If a 'Q' is accepted in the same cycle as the pulse, the session closes.
- R9: Any other accepted byte raises cmd_error for exactly the one clock that follows acceptance, and it changes no pin.
- R10: in_ready is 1 exactly when the session is open and no reply is waiting in the output stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | ASCII command byte |
| in_ready | output | 1 | Block takes the command byte this cycle |
| out_valid | output | 1 | Reply byte present |
| out_data | output | 8 | ASCII reply byte ('0' or '1') |
| out_ready | input | 1 | Receiver takes the reply byte this cycle |
| tdo | input | 1 | Data line coming back from the TAP |
| tck | output | 1 | JTAG clock level |
| tms | output | 1 | JTAG mode select level |
| tdi | output | 1 | JTAG data-in level |
| tap_reset | output | 1 | Reset request to the TAP, held RST_CYCLES clocks |
| cmd_error | output | 1 | One-cycle strobe for an unsupported byte |
| session_closed | output | 1 | High after quit until session_start |
| session_start | input | 1 | Strobe that re-opens a closed session |

## Verification
Internal faults show up at the ports within one or two clocks. A wrong decode lands on the pins, on cmd_error or on the reply stage in the very next cycle. A bad session or reply-pending flag shows first as a wrong in_ready level in the same cycle, and then as bytes that are lost or taken twice. A wrong reset counter makes the tap_reset pulse one clock too short or too long. The bench therefore compares every port on every cycle against a reference model, under random byte mixes and random backpressure.

// File: rtl/jbb_pkg.sv
package jbb_pkg;
    localparam int unsigned CHAR_W = 8;
    localparam int unsigned PIN_W  = 3;

    localparam logic [CHAR_W-1:0] CH_READ   = 8'h52;
    localparam logic [CHAR_W-1:0] CH_TRST   = 8'h72;
    localparam logic [CHAR_W-1:0] CH_LED_ON = 8'h42;
    localparam logic [CHAR_W-1:0] CH_LED_OFF= 8'h62;
    localparam logic [CHAR_W-1:0] CH_QUIT   = 8'h51;
    localparam logic [CHAR_W-1:0] CH_ZERO   = 8'h30;
    localparam logic [CHAR_W-1:0] CH_ONE    = 8'h31;
    localparam logic [CHAR_W-PIN_W-1:0] DIGIT_HI = 5'b00110;

    typedef enum logic [2:0] {
        OP_PINS,
        OP_READ,
        OP_TRST,
        OP_NOP,
        OP_QUIT,
        OP_BAD
    } op_e;
endpackage

// File: rtl/jbb_decode.sv
module jbb_decode
    import jbb_pkg::*;
(
    input  logic [CHAR_W-1:0] byte_i,
    output op_e               op_o,
    output logic [PIN_W-1:0]  pins_o
);
    always_comb begin
        pins_o = byte_i[PIN_W-1:0];
        if (byte_i[CHAR_W-1:PIN_W] == DIGIT_HI) begin
            op_o = OP_PINS;
        end else begin
            unique case (byte_i)
                CH_READ:               op_o = OP_READ;
                CH_TRST:               op_o = OP_TRST;
                CH_LED_ON, CH_LED_OFF: op_o = OP_NOP;
                CH_QUIT:               op_o = OP_QUIT;
                default:               op_o = OP_BAD;
            endcase
        end
    end
endmodule

// File: rtl/jbb_reply.sv
module jbb_reply
    import jbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              tdo_i,
    input  logic              ready_i,
    output logic              valid_o,
    output logic [CHAR_W-1:0] data_o
);
    typedef struct packed {
        logic              valid;
        logic [CHAR_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid && ready_i) slot_d.valid = 1'b0;
        if (load_i) begin
            slot_d.valid = 1'b1;
            slot_d.data  = tdo_i ? CH_ONE : CH_ZERO;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slot_q <= '{valid: 1'b0, data: CH_ZERO};
        else        slot_q <= slot_d;
    end

    assign valid_o = slot_q.valid;
    assign data_o  = slot_q.data;

    // R4
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(data_o)));

    // R3
    reply_ascii_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (data_o == CH_ZERO || data_o == CH_ONE));

    // R3
    reply_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (valid_o && data_o == ($past(tdo_i) ? CH_ONE : CH_ZERO)));
endmodule

// File: rtl/jbb_trst_timer.sv
module jbb_trst_timer #(
    parameter int unsigned CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic active_o
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start_i)           cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign active_o = (cnt_q != '0);

    // R5
    trst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> active_o);

    initial begin
        if (CYCLES < 1) $error("CYCLES must be at least 1");
    end
endmodule

// File: rtl/jtag_bitbang_decoder.sv
module jtag_bitbang_decoder
    import jbb_pkg::*;
#(
    parameter int unsigned RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CHAR_W-1:0] in_data,
    output logic              in_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    input  logic              out_ready,
    input  logic              tdo,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    output logic              tap_reset,
    output logic              cmd_error,
    output logic              session_closed,
    input  logic              session_start
);
    typedef struct packed {
        logic [PIN_W-1:0] pins;
        logic             closed;
        logic             err;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    op_e              op;
    logic [PIN_W-1:0] dec_pins;
    logic             accept;

    jbb_decode u_decode (
        .byte_i (in_data),
        .op_o   (op),
        .pins_o (dec_pins)
    );

    jbb_reply u_reply (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept && op == OP_READ),
        .tdo_i   (tdo),
        .ready_i (out_ready),
        .valid_o (out_valid),
        .data_o  (out_data)
    );

    jbb_trst_timer #(.CYCLES(RST_CYCLES)) u_trst (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept && op == OP_TRST),
        .active_o (tap_reset)
    );

    assign in_ready = !ctl_q.closed && !out_valid;
    assign accept   = in_valid && in_ready;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        if (session_start) ctl_d.closed = 1'b0;
        if (accept) begin
            unique case (op)
                OP_PINS: ctl_d.pins   = dec_pins;
                OP_QUIT: ctl_d.closed = 1'b1;
                OP_BAD:  ctl_d.err    = 1'b1;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '{pins: '0, closed: 1'b0, err: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign tck            = ctl_q.pins[2];
    assign tms            = ctl_q.pins[1];
    assign tdi            = ctl_q.pins[0];
    assign cmd_error      = ctl_q.err;
    assign session_closed = ctl_q.closed;

    // R7
    closed_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        session_closed |-> !in_ready);

    // R10
    reply_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    // R9
    err_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_error |-> $past(in_valid && in_ready));

    // R2
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_ready) |=> $stable({tck, tms, tdi}));

    // R8
    reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (session_start && !(in_valid && in_ready)) |=> !session_closed);
endmodule

// File: tb/jtag_bitbang_decoder_tb.sv
module jtag_bitbang_decoder_tb;
    localparam int unsigned RST_CYCLES = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_ready = 1'b0;
    logic       tdo = 1'b0;
    logic       tck, tms, tdi, tap_reset, cmd_error, session_closed;
    logic       session_start = 1'b0;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // reference model state
    logic [2:0] m_pins = '0;
    logic       m_ov = 1'b0;
    logic [7:0] m_od = 8'h30;
    int         m_rst = 0;
    logic       m_closed = 1'b0;
    logic       m_err = 1'b0;

    always #2.5 clk = ~clk;

    jtag_bitbang_decoder #(.RST_CYCLES(RST_CYCLES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
        .tdo(tdo), .tck(tck), .tms(tms), .tdi(tdi), .tap_reset(tap_reset),
        .cmd_error(cmd_error), .session_closed(session_closed),
        .session_start(session_start)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // 0 pins, 1 read, 2 trst, 3 blink, 4 quit, 5 unsupported
    function automatic int kind(logic [7:0] b);
        if (b >= 8'h30 && b <= 8'h37) return 0;
        if (b == 8'h52) return 1;
        if (b == 8'h72) return 2;
        if (b == 8'h42 || b == 8'h62) return 3;
        if (b == 8'h51) return 4;
        return 5;
    endfunction

    function automatic logic [7:0] reply_char(logic t);
        return t ? 8'h31 : 8'h30;
    endfunction

    // One clock: drive at a falling edge, check in_ready, advance the model,
    // then compare every output at the next falling edge.
    task automatic cycle(logic v, logic [7:0] b, logic t, logic ordy, logic ss);
        logic acc;
        in_valid = v; in_data = b; tdo = t; out_ready = ordy; session_start = ss;
        #0.5;
        check("R10 in_ready", in_ready, !m_closed && !m_ov);
        acc = v && !m_closed && !m_ov;
        @(negedge clk);
        m_err = 1'b0;
        if (m_ov && ordy) m_ov = 1'b0;
        if (m_rst > 0) m_rst--;
        if (ss) m_closed = 1'b0;
        if (acc) begin
            case (kind(b))
                0: m_pins = b[2:0];
                1: begin m_ov = 1'b1; m_od = reply_char(t); end
                2: m_rst = RST_CYCLES;
                4: m_closed = 1'b1;
                5: m_err = 1'b1;
                default: ;
            endcase
        end
        check("R2 pins", {tck, tms, tdi}, m_pins);
        check("R4 out_valid", out_valid, m_ov);
        if (m_ov) check("R3 out_data", out_data, m_od);
        check("R5 tap_reset", tap_reset, m_rst > 0);
        check("R9 cmd_error", cmd_error, m_err);
        check("R7 session_closed", session_closed, m_closed);
        in_valid = 1'b0; out_ready = 1'b0; session_start = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [2:0] held;
        void'($urandom(32'h1234abcd));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #0.5;
        // R1 reset state
        check("R1 pins", {tck, tms, tdi}, 3'b000);
        check("R1 tap_reset", tap_reset, 1'b0);
        check("R1 cmd_error", cmd_error, 1'b0);
        check("R1 out_valid", out_valid, 1'b0);
        check("R1 session_closed", session_closed, 1'b0);
        check("R1 in_ready", in_ready, 1'b1);
        @(negedge clk);

        // R2 every digit
        for (int d = 0; d < 8; d++) cycle(1'b1, 8'h30 + 8'(d), 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 8'h35, 1'b0, 1'b0, 1'b0);
        check("R2 digit 5", {tck, tms, tdi}, 3'b101);

        // R3 / R4 read with held backpressure
        cycle(1'b1, 8'h52, 1'b1, 1'b0, 1'b0);
        check("R3 reply one", out_data, 8'h31);
        cycle(1'b1, 8'h30, 1'b0, 1'b0, 1'b0);
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R4 held", {out_valid, out_data}, {1'b1, 8'h31});
        check("R4 byte not taken", {tck, tms, tdi}, 3'b101);
        cycle(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);
        check("R4 drained", out_valid, 1'b0);
        cycle(1'b1, 8'h52, 1'b0, 1'b1, 1'b0);
        check("R3 reply zero", out_data, 8'h30);
        cycle(1'b0, 8'h00, 1'b0, 1'b1, 1'b0);

        // R5 reset pulse width, pins unchanged
        cycle(1'b1, 8'h72, 1'b0, 1'b0, 1'b0);
        for (int i = 1; i < RST_CYCLES; i++) cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R5 last high", tap_reset, 1'b1);
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R5 ends", tap_reset, 1'b0);
        check("R5 pins kept", {tck, tms, tdi}, 3'b101);

        // R6 blink characters
        held = {tck, tms, tdi};
        cycle(1'b1, 8'h42, 1'b0, 1'b0, 1'b0);
        cycle(1'b1, 8'h62, 1'b1, 1'b0, 1'b0);
        check("R6 pins", {tck, tms, tdi}, held);
        check("R6 no error/reply", {cmd_error, out_valid}, 2'b00);

        // R9 unsupported byte
        cycle(1'b1, 8'h7a, 1'b0, 1'b0, 1'b0);
        check("R9 pulse", cmd_error, 1'b1);
        check("R9 pins", {tck, tms, tdi}, held);
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
        check("R9 one cycle", cmd_error, 1'b0);

        // R7 / R8 quit and reopen
        cycle(1'b1, 8'h51, 1'b0, 1'b0, 1'b0);
        check("R7 closed", {session_closed, in_ready}, 2'b10);
        cycle(1'b1, 8'h32, 1'b0, 1'b0, 1'b0);
        check("R7 digit ignored", {tck, tms, tdi}, held);
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
        check("R8 reopened", {session_closed, in_ready}, 2'b01);
        cycle(1'b1, 8'h51, 1'b0, 1'b0, 1'b1);
        check("R8 quit beats start", session_closed, 1'b1);
        cycle(1'b0, 8'h00, 1'b0, 1'b0, 1'b1);

        // random mix
        for (int n = 0; n < 3000; n++) begin
            int unsigned p;
            logic [7:0] b;
            p = $urandom_range(99);
            if (p < 55)      b = 8'h30 + 8'($urandom_range(7));
            else if (p < 68) b = 8'h52;
            else if (p < 73) b = 8'h72;
            else if (p < 78) b = ($urandom_range(1) != 0) ? 8'h42 : 8'h62;
            else if (p < 81) b = 8'h51;
            else             b = 8'($urandom_range(255));
            cycle($urandom_range(3) != 0, b, $urandom_range(1) != 0,
                  $urandom_range(1) != 0,
                  m_closed ? ($urandom_range(2) == 0) : ($urandom_range(30) == 0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule